// File: doc/BRIEF.md
# SPI Inactivity Watchdog Timer

This block watches the gap between completed SPI frames. It counts cycles of a 3.6864 MHz reference clock from the most recent restart. When the host has been silent for longer than the selected period, it reports a timeout. A 3-bit period select picks one of eight idle periods, from 50 ms up to 5 s. The block turns that code into a cycle count itself.

When a timeout occurs, the block drives a one-cycle pulse and sets a sticky flag. The flag stays set until the host writes a clear. Once it has expired, the counter parks at the terminal count until the next restart, so one idle spell yields exactly one pulse. A restart is any of these: a completed frame, a change of the period code, or the enable bit held low. Enable and period select are host-written control bits, held elsewhere. After reset they are expected to read 0 and 100 (2 s), so the watchdog starts out disabled.

A scale parameter divides every terminal count so that simulation runs short. Its default of 1 gives the real periods.

Top module: `spi_idle_watchdog`

## Requirements
- R1: After reset, `timeout_flag_o` and `timeout_pulse_o` are 0.
- R2: The terminal count for period code c is T(c) = floor(184320 * M(c) / SCALE_DIV), raised to a minimum of 1. M is 1, 2, 10, 20, 40, 60, 80, 100 for codes 0 through 7, which gives 50 ms, 100 ms, 500 ms, 1 s, 2 s, 3 s, 4 s and 5 s at 3.6864 MHz. With enable high and no further restart, `timeout_pulse_o` is high in the cycle that follows the T(c)-th rising edge after the last restart edge.
- R3: A rising edge that samples `frame_done_i` high restarts the count, so the next timeout comes T(c) edges later. That edge never produces a pulse. Frames spaced closer than T(c) prevent any timeout.
- R4: `timeout_pulse_o` lasts exactly one cycle. After a timeout the counter holds, and no further pulse occurs until a restart.
- R5: `timeout_flag_o` sets together with the pulse. It then stays set through frames, enable changes and code changes until an edge samples `flag_clear_i` high. Only a timeout makes it rise.
- R6: If `flag_clear_i` is sampled at the same edge that produces a timeout, the flag is still set.
- R7: An edge that samples `enable_i` low clears the count and produces no pulse. When enable returns high, the timeout follows T(c) edges after the last edge that sampled enable low.
- R8: An edge that samples a period code different from the code of the previous edge restarts the count. The next timeout uses the new code's T.
- R9: When SCALE_DIV makes the product of 184320 and M(c) fall below one cycle, the terminal count is 1, so a timeout follows one edge after a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 3.6864 MHz reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Watchdog enable control bit |
| period_sel_i | input | 3 | Idle period code |
| frame_done_i | input | 1 | One-cycle strobe for a completed valid SPI frame |
| flag_clear_i | input | 1 | Host clear of the sticky timeout flag |
| timeout_flag_o | output | 1 | Sticky timeout flag |
| timeout_pulse_o | output | 1 | One-cycle timeout pulse |

## Verification
A wrong count or a wrong terminal value shows up as a pulse that arrives early, late or never, measured in edges from the restart. Sweeping every period code therefore pins each table entry and the counter's off-by-one within one period. A counter that fails to hold, or a restart path that is missing, shows within one further period as an extra pulse. A faulty flag register shows on the cycle after the pulse, or on the cycle after a clear.

// File: rtl/spi_wdt_pkg.sv
`timescale 1ns/1ps
package spi_wdt_pkg;

    localparam int unsigned SEL_W          = 3;
    localparam int unsigned NUM_CODES      = 1 << SEL_W;
    // cycles of a 3.6864 MHz reference in 50 ms
    localparam int unsigned BASE_CYCLES    = 184320;
    localparam logic [SEL_W-1:0] SEL_RESET = 3'b100;

    // multiples of the 50 ms base period
    function automatic int unsigned code_mult(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 10;
            3'd3:    return 20;
            3'd4:    return 40;
            3'd5:    return 60;
            3'd6:    return 80;
            default: return 100;
        endcase
    endfunction

    function automatic int unsigned term_cycles(input logic [SEL_W-1:0] sel,
                                                input int unsigned div);
        int unsigned d;
        int unsigned t;
        d = (div == 0) ? 1 : div;
        t = (BASE_CYCLES * code_mult(sel)) / d;
        if (t == 0) t = 1;
        return t;
    endfunction

endpackage

// File: rtl/spi_wdt_period_map.sv
`timescale 1ns/1ps
module spi_wdt_period_map
    import spi_wdt_pkg::*;
#(
    parameter int unsigned SCALE_DIV = 1,
    parameter int unsigned CNT_W     = 25
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] term_o
);

    logic [CNT_W-1:0] term_tbl [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
        localparam int unsigned TERM = term_cycles(SEL_W'(g), SCALE_DIV);
        assign term_tbl[g] = CNT_W'(TERM);
    end

    assign term_o = term_tbl[sel_i];

endmodule

// File: rtl/spi_wdt_counter.sv
`timescale 1ns/1ps
module spi_wdt_counter
    import spi_wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 25
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             frame_done_i,
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       restart;

    always_comb begin
        st_d     = st_q;
        st_d.sel = period_sel_i;
        restart  = !enable_i || frame_done_i || (period_sel_i != st_q.sel);
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < term_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        hit_o = !restart && ((st_q.cnt + CNT_W'(1)) == term_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
            st_q.sel <= SEL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_wdt_flag.sv
`timescale 1ns/1ps
module spi_wdt_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic clear_i,
    output logic flag_o,
    output logic pulse_o
);

    typedef struct packed {
        logic flag;
        logic pulse;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = hit_i;
        // a new timeout takes precedence over a simultaneous clear
        st_d.flag  = hit_i || (st_q.flag && !clear_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/spi_idle_watchdog.sv
`timescale 1ns/1ps
module spi_idle_watchdog
    import spi_wdt_pkg::*;
#(
    parameter int unsigned SCALE_DIV = 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic [2:0] period_sel_i,
    input  logic       frame_done_i,
    input  logic       flag_clear_i,
    output logic       timeout_flag_o,
    output logic       timeout_pulse_o
);

    localparam int unsigned MAX_TERM = term_cycles(SEL_W'(NUM_CODES - 1), SCALE_DIV);
    localparam int unsigned CNT_W    = $clog2(MAX_TERM + 1);

    logic [CNT_W-1:0] term;
    logic             hit;

    spi_wdt_period_map #(
        .SCALE_DIV (SCALE_DIV),
        .CNT_W     (CNT_W)
    ) u_map (
        .sel_i  (period_sel_i),
        .term_o (term)
    );

    spi_wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enable_i     (enable_i),
        .frame_done_i (frame_done_i),
        .period_sel_i (period_sel_i),
        .term_i       (term),
        .hit_o        (hit)
    );

    spi_wdt_flag u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (hit),
        .clear_i (flag_clear_i),
        .flag_o  (timeout_flag_o),
        .pulse_o (timeout_pulse_o)
    );

endmodule

// File: rtl/spi_wdt_checker.sv
`timescale 1ns/1ps
module spi_wdt_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic frame_done_i,
    input logic flag_clear_i,
    input logic timeout_flag_o,
    input logic timeout_pulse_o
);

    a_r4_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_pulse_o |=> !timeout_pulse_o);

    a_r5_flag_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_pulse_o |-> timeout_flag_o);

    a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (timeout_flag_o && !flag_clear_i) |=> timeout_flag_o);

    a_r5_rise_only_on_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_flag_o) |-> timeout_pulse_o);

    a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !timeout_pulse_o);

    a_r3_frame_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_i |=> !timeout_pulse_o);

endmodule

bind spi_idle_watchdog spi_wdt_checker u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .enable_i        (enable_i),
    .frame_done_i    (frame_done_i),
    .flag_clear_i    (flag_clear_i),
    .timeout_flag_o  (timeout_flag_o),
    .timeout_pulse_o (timeout_pulse_o)
);

// File: tb/tb_spi_idle_watchdog.sv
`timescale 1ns/1ps
module tb_spi_idle_watchdog;

    localparam int unsigned DIV     = 18432;       // base period of 10 cycles
    localparam int unsigned DIV_MIN = 1000000000;  // every period floors to 1

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] sel = 3'b100;
    logic       frame_done = 1'b0;
    logic       flag_clear = 1'b0;
    logic       flag, pulse, flag_min, pulse_min;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_idle_watchdog #(.SCALE_DIV(DIV)) dut (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .period_sel_i(sel),
        .frame_done_i(frame_done), .flag_clear_i(flag_clear),
        .timeout_flag_o(flag), .timeout_pulse_o(pulse)
    );

    spi_idle_watchdog #(.SCALE_DIV(DIV_MIN)) dut_min (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .period_sel_i(sel),
        .frame_done_i(frame_done), .flag_clear_i(flag_clear),
        .timeout_flag_o(flag_min), .timeout_pulse_o(pulse_min)
    );

    function automatic int exp_term(input int code, input int unsigned div);
        int m;
        int t;
        case (code)
            0: m = 1;   1: m = 2;   2: m = 10;  3: m = 20;
            4: m = 40;  5: m = 60;  6: m = 80;  default: m = 100;
        endcase
        t = (184320 * m) / div;
        return (t < 1) ? 1 : t;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // count edges until the pulse is seen (0 = seen now)
    task automatic measure(input bit use_min, input int limit, output int k);
        k = 0;
        while (!(use_min ? pulse_min : pulse) && k < limit) begin
            tick();
            k++;
        end
    endtask

    task automatic frame();
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
    endtask

    task automatic count_pulses(input int n, output int p);
        p = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (pulse) p++;
        end
    endtask

    initial begin
        int k;
        int p;
        int t;
        repeat (4) tick();
        check(flag == 1'b0, "R1", "flag in reset", flag, 0);
        check(pulse == 1'b0, "R1", "pulse in reset", pulse, 0);
        rst_n = 1'b1;
        tick();
        check(flag == 1'b0 && pulse == 1'b0, "R1", "outputs after reset", {flag, pulse}, 0);

        // disabled after reset: no timeout
        count_pulses(500, p);
        check(p == 0, "R7", "pulses while disabled", p, 0);

        // enable at default code 4
        enable = 1'b1;
        tick();
        measure(1'b0, 2000, k);
        check(k == exp_term(4, DIV) - 1, "R7", "re-enable latency code 4", k, exp_term(4, DIV) - 1);
        tick();
        check(pulse == 1'b0, "R4", "pulse width", pulse, 0);
        check(flag == 1'b1, "R5", "flag set", flag, 1);
        clear_flag();
        check(flag == 1'b0, "R5", "flag cleared", flag, 0);

        // sweep every period code through code changes
        for (int c = 0; c < 8; c++) begin
            t = exp_term(c, DIV);
            sel = 3'(c);
            tick();
            measure(1'b0, 2000, k);
            check(k == t, "R2", $sformatf("latency code %0d", c), k, t);
            check(flag == 1'b1, "R5", $sformatf("flag with pulse code %0d", c), flag, 1);
            count_pulses(t + 5, p);
            check(p == 0, "R4", $sformatf("no repeat code %0d", c), p, 0);
            check(flag == 1'b1, "R5", $sformatf("flag held code %0d", c), flag, 1);
            clear_flag();
            check(flag == 1'b0, "R5", $sformatf("clear code %0d", c), flag, 0);
        end

        // frame restart
        sel = 3'd3;
        t = exp_term(3, DIV);
        repeat (120) tick();
        frame();
        measure(1'b0, 2000, k);
        check(k == t, "R3", "frame restart latency", k, t);
        clear_flag();
        frame();
        p = 0;
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < t - 50; i++) begin
                tick();
                if (pulse) p++;
            end
            frame();
            if (pulse) p++;
        end
        check(p == 0, "R3", "frequent frames keep quiet", p, 0);
        check(flag == 1'b0, "R3", "no flag with frequent frames", flag, 0);

        // clear and timeout on the same edge
        sel = 3'd2;
        t = exp_term(2, DIV);
        frame();
        repeat (t - 1) tick();
        check(pulse == 1'b0, "R6", "no pulse before terminal", pulse, 0);
        flag_clear = 1'b1;
        tick();
        flag_clear = 1'b0;
        check(pulse == 1'b1, "R6", "pulse at collision", pulse, 1);
        check(flag == 1'b1, "R6", "set wins over clear", flag, 1);
        clear_flag();

        // flag survives disable, frame and code change
        sel = 3'd0;
        tick();
        measure(1'b0, 2000, k);
        check(k == exp_term(0, DIV), "R8", "latency code 0", k, exp_term(0, DIV));
        enable = 1'b0;
        frame();
        sel = 3'd5;
        repeat (20) tick();
        check(flag == 1'b1, "R5", "flag through disable/frame/code", flag, 1);
        clear_flag();
        count_pulses(300, p);
        check(p == 0 && flag == 1'b0, "R7", "quiet while disabled", p + flag, 0);
        sel = 3'd0;
        tick();
        enable = 1'b1;
        tick();
        measure(1'b0, 2000, k);
        check(k == exp_term(0, DIV) - 1, "R7", "re-enable latency code 0", k, exp_term(0, DIV) - 1);
        clear_flag();

        // enable dropped mid-count
        sel = 3'd4;
        repeat (300) tick();
        enable = 1'b0;
        tick();
        enable = 1'b1;
        tick();
        measure(1'b0, 2000, k);
        check(k == exp_term(4, DIV) - 1, "R7", "mid-count disable restarts", k, exp_term(4, DIV) - 1);
        clear_flag();

        // code change mid-count
        sel = 3'd2;
        repeat (60) tick();
        sel = 3'd1;
        tick();
        measure(1'b0, 2000, k);
        check(k == exp_term(1, DIV), "R8", "code change restart", k, exp_term(1, DIV));
        clear_flag();

        // minimum terminal count of 1
        for (int c = 0; c < 8; c++) begin
            sel = 3'(c);
            tick();
            frame();
            measure(1'b1, 50, k);
            check(k == exp_term(c, DIV_MIN), "R9", $sformatf("floor latency code %0d", c), k, 1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule